// File: doc/BRIEF.md
# Per-Channel DAC Code Trim

This block sits in front of a multi-channel, 16-bit digital-to-analog converter and applies a straight-line correction to each channel's input code before it reaches the converter. Every channel keeps three values: an input data code, a gain word and an offset word. Gain at all-ones means a gain of exactly one. Offset at midscale means zero offset. All three are written through a small register-write port that carries a channel index and a field select.

When a load request names a channel, the block reads that channel's three values and computes `((data * (gain + 1)) >> 16) + offset - 32768` at full precision. It clamps the result into the unsigned 16-bit code range. It then presents the corrected code together with the channel index and a one-cycle valid strobe. The datapath is a two-stage pipeline and accepts a new load on every cycle.

Top module: `chan_trim_top`

## Requirements
- R1: Synchronous reset sets every gain word to 65535, every offset word to 32768 and every data code to 0, and drives `outValid` low.
- R2: A write with `wrEn` high stores `wrValue` into the channel named by `wrChan`. The field is chosen by `wrSel`: 0 is the data code, 1 is the gain word and 2 is the offset word. A select of 3 changes nothing.
- R3: The corrected code equals `((data * (gain + 1)) >> 16) + offset - 32768`, computed without loss of precision before clamping.
- R4: With gain 65535 and offset 32768, the corrected code equals the input data code for every input from 0 to 65535.
- R5: A sum above 65535 is presented as 65535 and never wraps.
- R6: A negative sum is presented as 0.
- R7: A load request sampled at clock edge N makes `outValid` high for the one cycle after edge N+1. In that cycle `outChan` carries the requested channel index.
- R8: Loads on consecutive cycles produce results on consecutive cycles, in request order.
- R9: A load uses the register values held before its own clock edge. A write in the same cycle as a load to the same channel takes effect only from the next load.
- R10: While `outValid` is low, `outCode` holds its last value.
- R11: With gain 63999 and offset 33536, input 0 maps to 768 and input 65535 maps to 64767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write request |
| wrChan | input | 3 | Channel index of the write |
| wrSel | input | 2 | Field select: 0 data, 1 gain, 2 offset, 3 none |
| wrValue | input | 16 | Value to write |
| ldEn | input | 1 | Load request |
| ldChan | input | 3 | Channel index of the load |
| outCode | output | 16 | Corrected, clamped code |
| outChan | output | 3 | Channel index of the result |
| outValid | output | 1 | Result strobe, one cycle per load |

## Verification
The bench builds the block with its default parameters: eight channels and a 16-bit code. This puts the real code extremes 0 and 65535 within reach, along with the all-ones gain and the midscale offset. Gains of 0 and half scale are also covered. The vectors are spread over all eight channels, so each channel's registers are written and read back. Directed sequences cover back-to-back loads, a write and a load to the same channel in the same cycle, the unused select value, and the register state after a second reset.

// File: rtl/chan_trim_pkg.sv
package chan_trim_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_GAIN = 2'd1,
    SEL_OFS  = 2'd2,
    SEL_NONE = 2'd3
  } fieldSel_t;

  typedef struct packed {
    logic wrData;
    logic wrGain;
    logic wrOfs;
    logic load;
  } trimStrobe_t;

endpackage

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import chan_trim_pkg::*;
(
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic        ldEn,
  output trimStrobe_t strobe
);

  always_comb begin
    strobe        = '0;
    strobe.load   = ldEn;
    if (wrEn) begin
      unique case (fieldSel_t'(wrSel))
        SEL_DATA: strobe.wrData = 1'b1;
        SEL_GAIN: strobe.wrGain = 1'b1;
        SEL_OFS:  strobe.wrOfs  = 1'b1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/trim_datapath.sv
module trim_datapath
  import chan_trim_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int CODE_W   = 16,
  localparam int CH_W    = $clog2(NUM_CHAN),
  localparam int PROD_W  = 2 * CODE_W + 1,
  localparam int SUM_W   = CODE_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  trimStrobe_t       strobe,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [CODE_W-1:0] wrValue,
  input  logic [CH_W-1:0]   ldChan,
  output logic [CODE_W-1:0] outCode,
  output logic [CH_W-1:0]   outChan,
  output logic              outValid
);

  localparam logic [CODE_W-1:0] GAIN_UNITY = '1;
  localparam logic [CODE_W-1:0] OFS_ZERO   = CODE_W'(1) << (CODE_W - 1);
  localparam logic signed [SUM_W-1:0] MID_S = SUM_W'(1) << (CODE_W - 1);
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'((SUM_W'(1) << CODE_W) - 1);

  logic [CODE_W-1:0] dataReg [NUM_CHAN];
  logic [CODE_W-1:0] gainReg [NUM_CHAN];
  logic [CODE_W-1:0] ofsReg  [NUM_CHAN];

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    logic hit;
    assign hit = (wrChan == CH_W'(ch));
    always_ff @(posedge clk) begin
      if (rst) begin
        dataReg[ch] <= '0;
        gainReg[ch] <= GAIN_UNITY;
        ofsReg[ch]  <= OFS_ZERO;
      end else if (hit) begin
        if (strobe.wrData) dataReg[ch] <= wrValue;
        if (strobe.wrGain) gainReg[ch] <= wrValue;
        if (strobe.wrOfs)  ofsReg[ch]  <= wrValue;
      end
    end
  end

  // Stage 1: scaled product, kept at full width
  logic [CODE_W:0]   gainP1;
  logic [PROD_W-1:0] prodFull;
  assign gainP1   = {1'b0, gainReg[ldChan]} + (CODE_W + 1)'(1);
  assign prodFull = PROD_W'(dataReg[ldChan]) * PROD_W'(gainP1);

  logic [CODE_W:0]   scaledS1;
  logic [CODE_W-1:0] ofsS1;
  logic [CH_W-1:0]   chanS1;
  logic              validS1;

  always_ff @(posedge clk) begin
    if (rst) begin
      validS1  <= 1'b0;
      scaledS1 <= '0;
      ofsS1    <= '0;
      chanS1   <= '0;
    end else begin
      validS1 <= strobe.load;
      if (strobe.load) begin
        scaledS1 <= prodFull[PROD_W-1:CODE_W];
        ofsS1    <= ofsReg[ldChan];
        chanS1   <= ldChan;
      end
    end
  end

  // Stage 2: offset, signed sum and clamp
  logic signed [SUM_W-1:0] sumS;
  logic [CODE_W-1:0]       clampCode;
  assign sumS = $signed({2'b00, scaledS1}) + $signed({3'b000, ofsS1}) - MID_S;

  always_comb begin
    if (sumS < 0)          clampCode = '0;
    else if (sumS > MAX_S) clampCode = '1;
    else                   clampCode = sumS[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outCode  <= '0;
      outChan  <= '0;
    end else begin
      outValid <= validS1;
      if (validS1) begin
        outCode <= clampCode;
        outChan <= chanS1;
      end
    end
  end

endmodule

// File: rtl/chan_trim_top.sv
module chan_trim_top
  import chan_trim_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int CODE_W   = 16,
  localparam int CH_W    = $clog2(NUM_CHAN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrChan,
  input  logic [1:0]        wrSel,
  input  logic [CODE_W-1:0] wrValue,
  input  logic              ldEn,
  input  logic [CH_W-1:0]   ldChan,
  output logic [CODE_W-1:0] outCode,
  output logic [CH_W-1:0]   outChan,
  output logic              outValid
);

  trimStrobe_t strobe;

  trim_ctrl i_ctrl (
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .ldEn   (ldEn),
    .strobe (strobe)
  );

  trim_datapath #(
    .NUM_CHAN (NUM_CHAN),
    .CODE_W   (CODE_W)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .wrChan   (wrChan),
    .wrValue  (wrValue),
    .ldChan   (ldChan),
    .outCode  (outCode),
    .outChan  (outChan),
    .outValid (outValid)
  );

endmodule

// File: rtl/chan_trim_checker.sv
module chan_trim_checker #(
  parameter int NUM_CHAN = 8,
  parameter int CODE_W   = 16,
  localparam int CH_W    = $clog2(NUM_CHAN)
) (
  input logic              clk,
  input logic              rst,
  input logic              ldEn,
  input logic [CH_W-1:0]   ldChan,
  input logic [CODE_W-1:0] outCode,
  input logic [CH_W-1:0]   outChan,
  input logic              outValid
);

  logic [1:0]      ldPipe;
  logic [CH_W-1:0] chPipe0, chPipe1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ldPipe  <= '0;
      chPipe0 <= '0;
      chPipe1 <= '0;
    end else begin
      ldPipe  <= {ldPipe[0], ldEn};
      chPipe0 <= ldChan;
      chPipe1 <= chPipe0;
    end
  end

  // R1: reset drops the strobe
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !outValid);

  // R7, R8: strobe follows each load two edges later
  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    outValid == ldPipe[1]);

  // R7: channel tag matches the request
  a_r7_chan_tag: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outChan == chPipe1);

  // R10: code holds between results
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outCode));

endmodule

bind chan_trim_top chan_trim_checker #(
  .NUM_CHAN (NUM_CHAN),
  .CODE_W   (CODE_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .ldEn     (ldEn),
  .ldChan   (ldChan),
  .outCode  (outCode),
  .outChan  (outChan),
  .outValid (outValid)
);

// File: tb/test_chan_trim_top.sv
module test_chan_trim_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrChan = '0;
  logic [1:0]  wrSel = '0;
  logic [15:0] wrValue = '0;
  logic        ldEn = 1'b0;
  logic [2:0]  ldChan = '0;
  logic [15:0] outCode;
  logic [2:0]  outChan;
  logic        outValid;

  int checks = 0;
  int fails  = 0;
  logic [15:0] holdVal;

  always #4 clk = ~clk;

  chan_trim_top i_chan_trim_top (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrChan(wrChan), .wrSel(wrSel),
    .wrValue(wrValue), .ldEn(ldEn), .ldChan(ldChan),
    .outCode(outCode), .outChan(outChan), .outValid(outValid)
  );

  // data, gain, offset, expected code
  localparam logic [15:0] VEC [12][4] = '{
    '{16'd0,     16'd65535, 16'd32768, 16'd0},      // R4 low end
    '{16'd65535, 16'd65535, 16'd32768, 16'd65535},  // R4 high end
    '{16'd12345, 16'd65535, 16'd32768, 16'd12345},  // R4 midrange
    '{16'd0,     16'd63999, 16'd33536, 16'd768},    // R11
    '{16'd65535, 16'd63999, 16'd33536, 16'd64767},  // R11
    '{16'd65535, 16'd65535, 16'd33536, 16'd65535},  // R5 clamp high
    '{16'd100,   16'd65535, 16'd32000, 16'd0},      // R6 clamp low
    '{16'd32768, 16'd32767, 16'd32768, 16'd16384},  // R3 half gain
    '{16'd1000,  16'd65535, 16'd32868, 16'd1100},   // R3 positive offset
    '{16'd40000, 16'd0,     16'd32768, 16'd0},      // R3 minimum gain
    '{16'd65535, 16'd0,     16'd65535, 16'd32767},  // R3 max offset
    '{16'd0,     16'd65535, 16'd0,     16'd0}       // R6 most negative
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [2:0] ch, logic [1:0] sel, logic [15:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrChan = ch; wrSel = sel; wrValue = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // request at one edge, result visible after the next
  task automatic loadCheck(string req, logic [2:0] ch, logic [15:0] exp);
    @(negedge clk);
    ldEn = 1'b1; ldChan = ch;
    @(negedge clk);
    ldEn = 1'b0;
    check({req, " early valid"}, {15'd0, outValid}, 16'd0);
    @(negedge clk);
    check({req, " valid"}, {15'd0, outValid}, 16'd1);
    check({req, " chan"}, {13'd0, outChan}, {13'd0, ch});
    check({req, " code"}, outCode, exp);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 valid in reset", {15'd0, outValid}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {15'd0, outValid}, 16'd0);
    loadCheck("R1 data reset", 3'd5, 16'd0);

    for (int i = 0; i < 12; i++) begin
      writeReg(3'(i % 8), 2'd0, VEC[i][0]);
      writeReg(3'(i % 8), 2'd1, VEC[i][1]);
      writeReg(3'(i % 8), 2'd2, VEC[i][2]);
      loadCheck("R2 R3 vector", 3'(i % 8), VEC[i][3]);
    end

    // R10: hold after the strobe drops
    holdVal = outCode;
    @(negedge clk);
    check("R10 valid low", {15'd0, outValid}, 16'd0);
    check("R10 code held", outCode, holdVal);

    // R8: back-to-back loads, channels 0 and 1 (vectors 8 and 9)
    @(negedge clk); ldEn = 1'b1; ldChan = 3'd0;
    @(negedge clk); ldChan = 3'd1;
    @(negedge clk); ldEn = 1'b0;
    check("R8 first valid", {15'd0, outValid}, 16'd1);
    check("R8 first code", outCode, 16'd1100);
    @(negedge clk);
    check("R8 second valid", {15'd0, outValid}, 16'd1);
    check("R8 second chan", {13'd0, outChan}, 16'd1);
    check("R8 second code", outCode, 16'd0);

    // R9: write and load same channel in one cycle
    writeReg(3'd6, 2'd1, 16'd65535);
    writeReg(3'd6, 2'd2, 16'd32768);
    writeReg(3'd6, 2'd0, 16'd500);
    @(negedge clk);
    wrEn = 1'b1; wrChan = 3'd6; wrSel = 2'd0; wrValue = 16'd900;
    ldEn = 1'b1; ldChan = 3'd6;
    @(negedge clk);
    wrEn = 1'b0; ldEn = 1'b0;
    @(negedge clk);
    check("R9 old value used", outCode, 16'd500);
    loadCheck("R9 new value next load", 3'd6, 16'd900);

    // R2: select 3 changes nothing
    writeReg(3'd6, 2'd3, 16'd7);
    loadCheck("R2 unused select", 3'd6, 16'd900);

    // R1: second reset restores gain and offset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R1 valid after second reset", {15'd0, outValid}, 16'd0);
    loadCheck("R1 data cleared", 3'd4, 16'd0);
    writeReg(3'd3, 2'd0, 16'd40000);
    loadCheck("R1 R4 unity after reset", 3'd3, 16'd40000);

    summary();
  end

endmodule